// File: doc/BRIEF.md
# Transmit Statistics Counter Bank

This block sits beside the transmit side of a multi-port switch and turns a stream of per-frame completion reports into running statistics. Each report names the port that sent the frame, its length in bytes, whether it went out successfully, whether it had to wait for the medium, and the destination address, type field and opcode of the frame. From the address, type and opcode the block decides whether the frame is broadcast or a pause frame. It then bumps every counter that matches the report in that port's own counter set.

Each port owns eleven frame counters and one byte accumulator. Frame counters cover deferrals, pause frames, good frames, broadcasts, runts, and six length bands. All counters wrap at their width and never saturate. Software reads any counter through a simple registered read port: it presents a port number and a counter index, and the value appears one cycle later. A read that lands in the same cycle as an update returns the count from before that update.

Top module: `tx_stat_bank`

## Requirements
- R1: After reset every counter of every port reads as zero, and `rd_data` is zero.
- R2: Counter index 0 (deferred) increments for every report with `st_deferred` set, whether or not `st_ok` is set.
- R3: Counter index 1 (pause) increments for a successful report only when `st_etype` is 0x8808 and `st_opcode` is 0x0001. A mismatch in either field leaves it unchanged.
- R4: Counter index 2 (good frames) increments for every report with `st_ok` set.
- R5: Counter index 3 (broadcast) increments for a successful report whose `st_dest` is all ones.
- R6: Counter index 4 (runt) increments for a successful report shorter than 64 bytes. Such a frame is counted in no length band.
- R7: Successful reports of 64 bytes or more increment exactly one length-band counter. The bands are index 5 (exactly 64), 6 (65 to 127), 7 (128 to 255), 8 (256 to 511), 9 (512 to 1023) and 10 (1024 and longer).
- R8: Counter index 11 (bytes) adds `st_len` for every successful report.
- R9: A report with `st_ok` clear changes no counter other than the deferred counter.
- R10: A report updates only the counter set of `st_port`. A report whose port number is NUM_PORTS or greater changes nothing.
- R11: When `rd_en` is high, the selected counter appears zero-extended on `rd_data` one cycle later. Index 12 or above, or a port number of NUM_PORTS or greater, reads as zero.
- R12: A read and an update of the same counter in the same cycle return the value from before the update.
- R13: Frame counters wrap from all ones to zero at CNT_W bits. The byte counter wraps modulo 2^BYTE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Frame report present this cycle |
| st_port | input | PORT_W | Port that sent the frame |
| st_len | input | LEN_W | Frame length in bytes |
| st_ok | input | 1 | Frame was sent successfully |
| st_deferred | input | 1 | Frame waited for the medium |
| st_dest | input | 48 | Destination address of the frame |
| st_etype | input | 16 | Type field of the frame |
| st_opcode | input | 16 | Control opcode of the frame |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port whose counter is read |
| rd_idx | input | 4 | Counter index, 0 to 11 |
| rd_data | output | BYTE_W | Counter value, valid the cycle after `rd_en` |

## Verification
Counter state can only be seen through the read port, so a wrong increment shows up only when software next reads that counter. That read returns its value exactly one cycle after the request. A band classification error also shows up as a difference between adjacent band counters. The byte counter gives an independent cross-check, because a wrong length or a missed success gate shifts it by whole frame lengths. Wrap errors appear only after a full counter period. For that reason the bench narrows the counter widths, so that both wraps can be reached in a few hundred frames.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;

  // counter index map seen by software
  localparam int C_DEFER  = 0;
  localparam int C_PAUSE  = 1;
  localparam int C_GOOD   = 2;
  localparam int C_BCAST  = 3;
  localparam int C_RUNT   = 4;
  localparam int C_B64    = 5;
  localparam int C_B1024  = 10;
  localparam int C_BYTES  = 11;
  localparam int NUM_FRAME_CNT = 11;
  localparam int NUM_CNT  = 12;
  localparam int NUM_BAND = 6;
  localparam int MIN_FRAME = 64;

  localparam logic [15:0] PAUSE_ETYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;

  typedef logic [NUM_BAND-1:0] band_t;

  function automatic logic is_pause(input logic [15:0] et, input logic [15:0] op);
    return (et == PAUSE_ETYPE) && (op == PAUSE_OPCODE);
  endfunction

  function automatic logic is_bcast(input logic [47:0] da);
    return &da;
  endfunction

  // one-hot band for lengths of MIN_FRAME and above, zero below
  function automatic band_t band_of(input int unsigned n);
    band_t b;
    b = '0;
    if (n == MIN_FRAME)      b[0] = 1'b1;
    else if (n > MIN_FRAME) begin
      if (n < 128)           b[1] = 1'b1;
      else if (n < 256)      b[2] = 1'b1;
      else if (n < 512)      b[3] = 1'b1;
      else if (n < 1024)     b[4] = 1'b1;
      else                   b[5] = 1'b1;
    end
    return b;
  endfunction

endpackage

// File: rtl/txs_classify.sv
module txs_classify
  import tx_stat_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid,
  input  logic                     ok,
  input  logic                     deferred,
  input  logic [LEN_W-1:0]         len,
  input  logic [47:0]              dest,
  input  logic [15:0]              etype,
  input  logic [15:0]              opcode,
  output logic [NUM_FRAME_CNT-1:0] inc_vec,
  output logic                     add_bytes
);

  logic  good;
  logic  runt;
  band_t band;

  always_comb begin
    good = valid && ok;
    runt = good && (32'(len) < MIN_FRAME);
    band = (good && !runt) ? band_of(32'(len)) : '0;

    inc_vec                    = '0;
    inc_vec[C_DEFER]           = valid && deferred;
    inc_vec[C_PAUSE]           = good && is_pause(etype, opcode);
    inc_vec[C_GOOD]            = good;
    inc_vec[C_BCAST]           = good && is_bcast(dest);
    inc_vec[C_RUNT]            = runt;
    inc_vec[C_B1024:C_B64]     = band;
    add_bytes                  = good;
  end

  assert_band_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ok && (32'(len) >= MIN_FRAME)) |-> ($countones(inc_vec[C_B1024:C_B64]) == 1));

  assert_runt_no_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_vec[C_RUNT] |-> (inc_vec[C_B1024:C_B64] == '0));

  assert_fail_only_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ok) |-> ((inc_vec[C_BYTES-1:C_PAUSE] == '0) && !add_bytes));

endmodule

// File: rtl/txs_port_bank.sv
module txs_port_bank
  import tx_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 64,
  parameter int LEN_W  = 14
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  hit,
  input  logic [NUM_FRAME_CNT-1:0]              inc_vec,
  input  logic                                  add_bytes,
  input  logic [LEN_W-1:0]                      len,
  output logic [NUM_FRAME_CNT-1:0][CNT_W-1:0]   frame_cnt,
  output logic [BYTE_W-1:0]                     byte_cnt
);

  logic [NUM_FRAME_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0]                   bytes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bytes_q <= '0;
    end else if (hit) begin
      for (int i = 0; i < NUM_FRAME_CNT; i++) begin
        if (inc_vec[i]) cnt_q[i] <= cnt_q[i] + CNT_W'(1);
      end
      if (add_bytes) bytes_q <= bytes_q + BYTE_W'(len);
    end
  end

  assign frame_cnt = cnt_q;
  assign byte_cnt  = bytes_q;

  for (genvar g = 0; g < NUM_FRAME_CNT; g++) begin : g_chk
    assert_step_wrap_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && inc_vec[g]) |=> (frame_cnt[g] == $past(frame_cnt[g]) + CNT_W'(1)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && inc_vec[g]) |=> $stable(frame_cnt[g]));
  end

  assert_bytes_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && add_bytes) |=> (byte_cnt == $past(byte_cnt) + BYTE_W'($past(len))));

  assert_bytes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && add_bytes) |=> $stable(byte_cnt));

endmodule

// File: rtl/txs_read_mux.sv
module txs_read_mux
  import tx_stat_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 2,
  parameter int CNT_W     = 32,
  parameter int BYTE_W    = 64
) (
  input  logic                                                 clk,
  input  logic                                                 rst_n,
  input  logic                                                 rd_en,
  input  logic [PORT_W-1:0]                                    rd_port,
  input  logic [3:0]                                           rd_idx,
  input  logic [NUM_PORTS-1:0][NUM_FRAME_CNT-1:0][CNT_W-1:0]   frame_all,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]                     byte_all,
  output logic [BYTE_W-1:0]                                    rd_data
);

  logic [BYTE_W-1:0] sel;
  logic              bad_addr;

  always_comb begin
    sel      = '0;
    bad_addr = (32'(rd_port) >= NUM_PORTS) || (32'(rd_idx) >= NUM_CNT);
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (32'(rd_port) == p) begin
        if (32'(rd_idx) < NUM_FRAME_CNT) sel = BYTE_W'(frame_all[p][rd_idx]);
        else if (32'(rd_idx) == C_BYTES) sel = byte_all[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end

  assert_bad_addr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bad_addr) |=> (rd_data == '0));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/tx_stat_bank.sv
module tx_stat_bank
  import tx_stat_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int CNT_W     = 32,
  parameter int BYTE_W    = 64,
  parameter int LEN_W     = 14,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [PORT_W-1:0] st_port,
  input  logic [LEN_W-1:0]  st_len,
  input  logic              st_ok,
  input  logic              st_deferred,
  input  logic [47:0]       st_dest,
  input  logic [15:0]       st_etype,
  input  logic [15:0]       st_opcode,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [3:0]        rd_idx,
  output logic [BYTE_W-1:0] rd_data
);

  logic [NUM_FRAME_CNT-1:0]                               inc_vec;
  logic                                                   add_bytes;
  logic [NUM_PORTS-1:0]                                   port_hit;
  logic [NUM_PORTS-1:0][NUM_FRAME_CNT-1:0][CNT_W-1:0]     frame_all;
  logic [NUM_PORTS-1:0][BYTE_W-1:0]                       byte_all;

  txs_classify #(.LEN_W(LEN_W)) u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (st_valid),
    .ok        (st_ok),
    .deferred  (st_deferred),
    .len       (st_len),
    .dest      (st_dest),
    .etype     (st_etype),
    .opcode    (st_opcode),
    .inc_vec   (inc_vec),
    .add_bytes (add_bytes)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_hit[p] = st_valid && (32'(st_port) == p);

    txs_port_bank #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (port_hit[p]),
      .inc_vec   (inc_vec),
      .add_bytes (add_bytes),
      .len       (st_len),
      .frame_cnt (frame_all[p]),
      .byte_cnt  (byte_all[p])
    );
  end

  txs_read_mux #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .CNT_W     (CNT_W),
    .BYTE_W    (BYTE_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_port   (rd_port),
    .rd_idx    (rd_idx),
    .frame_all (frame_all),
    .byte_all  (byte_all),
    .rd_data   (rd_data)
  );

  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_hit));

  assert_bad_port_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && (32'(st_port) >= NUM_PORTS)) |-> (port_hit == '0));

endmodule

// File: tb/tx_stat_bank_test.sv
`timescale 1ns/1ps
module tx_stat_bank_test;

  localparam int NP = 3;
  localparam logic [15:0] FMASK = 16'h00FF;  // CNT_W = 8 in this bench
  localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UC    = 48'h0200_1234_5678;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [1:0]  st_port = '0;
  logic [13:0] st_len = '0;
  logic        st_ok = 1'b0;
  logic        st_deferred = 1'b0;
  logic [47:0] st_dest = '0;
  logic [15:0] st_etype = '0;
  logic [15:0] st_opcode = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_port = '0;
  logic [3:0]  rd_idx = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] model [0:NP-1][0:11];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  tx_stat_bank #(.NUM_PORTS(NP), .CNT_W(8), .BYTE_W(16), .LEN_W(14)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_port(st_port),
    .st_len(st_len), .st_ok(st_ok), .st_deferred(st_deferred),
    .st_dest(st_dest), .st_etype(st_etype), .st_opcode(st_opcode),
    .rd_en(rd_en), .rd_port(rd_port), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // independent model of the requirements
  task automatic model_apply(input int p, input int len, input bit ok, input bit dfr,
                             input logic [47:0] da, input logic [15:0] et, input logic [15:0] op);
    int band;
    if (p >= NP) return;                                   // R10
    if (dfr) model[p][0] = (model[p][0] + 1) & FMASK;      // R2
    if (!ok) return;                                       // R9
    model[p][2] = (model[p][2] + 1) & FMASK;               // R4
    if (et == 16'h8808 && op == 16'h0001) model[p][1] = (model[p][1] + 1) & FMASK; // R3
    if (da == BC) model[p][3] = (model[p][3] + 1) & FMASK; // R5
    if (len < 64) band = 4;                                // R6
    else if (len == 64) band = 5;                          // R7
    else if (len <= 127) band = 6;
    else if (len <= 255) band = 7;
    else if (len <= 511) band = 8;
    else if (len <= 1023) band = 9;
    else band = 10;
    model[p][band] = (model[p][band] + 1) & FMASK;
    model[p][11] = model[p][11] + 16'(len);                // R8, R13 wrap mod 2^16
  endtask

  function automatic logic [15:0] expect_of(input int p, input int idx);
    if (p >= NP || idx >= 12) return 16'h0;                // R11
    return model[p][idx];
  endfunction

  task automatic set_report(input int p, input int len, input bit ok, input bit dfr,
                            input logic [47:0] da, input logic [15:0] et, input logic [15:0] op);
    st_valid = 1'b1; st_port = 2'(p); st_len = 14'(len); st_ok = ok;
    st_deferred = dfr; st_dest = da; st_etype = et; st_opcode = op;
    model_apply(p, len, ok, dfr, da, et, op);
  endtask

  task automatic set_read(input int p, input int idx, input string tag);
    rd_en = 1'b1; rd_port = 2'(p); rd_idx = 4'(idx);
    exp_q.push_back(expect_of(p, idx));
    tag_q.push_back(tag);
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    st_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic send(input int p, input int len, input bit ok, input bit dfr,
                      input logic [47:0] da, input logic [15:0] et, input logic [15:0] op);
    set_report(p, len, ok, dfr, da, et, op);
    finish_cycle();
  endtask

  task automatic read(input int p, input int idx, input string tag);
    set_read(p, idx, tag);
    finish_cycle();
  endtask

  task automatic read_all(input int p, input string tag);
    for (int i = 0; i < 12; i++) read(p, i, tag);
  endtask

  // monitor: compare each read one cycle after it was issued
  always @(posedge clk) rd_seen <= rd_en && rst_n;
  always @(negedge clk) begin
    if (rd_seen && !done) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4ns * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < 12; i++) model[p][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;                                              // R1 direct
    if (rd_data !== 16'h0) begin
      fails++;
      $display("FAIL R1: rd_data actual %h expected 0000", rd_data);
    end
    read_all(0, "R1");
    read_all(2, "R1");
    read(0, 12, "R11");
    read(1, 15, "R11");

    // length bands and runts on port 0
    send(0, 64,   1, 0, UC, 16'h0800, 16'h0);
    send(0, 63,   1, 0, UC, 16'h0800, 16'h0);
    send(0, 20,   1, 0, UC, 16'h0800, 16'h0);
    send(0, 65,   1, 0, UC, 16'h0800, 16'h0);
    send(0, 127,  1, 0, UC, 16'h0800, 16'h0);
    send(0, 128,  1, 0, UC, 16'h0800, 16'h0);
    send(0, 255,  1, 0, UC, 16'h0800, 16'h0);
    send(0, 256,  1, 0, UC, 16'h0800, 16'h0);
    send(0, 511,  1, 0, UC, 16'h0800, 16'h0);
    send(0, 512,  1, 0, UC, 16'h0800, 16'h0);
    send(0, 1023, 1, 0, UC, 16'h0800, 16'h0);
    send(0, 1024, 1, 0, UC, 16'h0800, 16'h0);
    send(0, 1518, 1, 0, UC, 16'h0800, 16'h0);
    // deferral, failures, broadcast, pause decoding
    send(0, 100,  0, 1, BC, 16'h8808, 16'h0001);           // R9: only defer
    send(0, 70,   1, 1, UC, 16'h0800, 16'h0);              // R2
    send(0, 64,   1, 0, BC, 16'h0800, 16'h0);              // R5
    send(0, 300,  0, 0, BC, 16'h0800, 16'h0);              // R9
    send(0, 64,   1, 0, UC, 16'h8808, 16'h0001);           // R3
    send(0, 64,   1, 0, UC, 16'h8808, 16'h0002);           // R3 wrong opcode
    send(0, 64,   1, 0, UC, 16'h8809, 16'h0001);           // R3 wrong type
    send(0, 64,   1, 0, 48'hFFFF_FFFF_FFFE, 16'h0800, 16'h0); // R5 near miss
    read(0, 0, "R2");
    read(0, 1, "R3");
    read(0, 2, "R4");
    read(0, 3, "R5");
    read(0, 4, "R6");
    for (int i = 5; i <= 10; i++) read(0, i, "R7");
    read(0, 11, "R8");
    read_all(0, "R9");
    read_all(1, "R10");

    // per-port separation
    send(1, 200, 1, 1, BC, 16'h0800, 16'h0);
    send(1, 40,  1, 0, UC, 16'h8808, 16'h0001);
    send(3, 500, 1, 1, BC, 16'h8808, 16'h0001);            // R10 ignored
    read_all(1, "R10");
    read_all(0, "R10");
    read_all(2, "R10");
    read(3, 2, "R11");

    // same-cycle read and update
    set_read(2, 2, "R12");
    set_report(2, 64, 1, 0, UC, 16'h0800, 16'h0);
    finish_cycle();
    read(2, 2, "R12");
    set_read(2, 11, "R12");
    set_report(2, 900, 1, 0, UC, 16'h0800, 16'h0);
    finish_cycle();
    read(2, 11, "R12");

    // wrap of 8-bit frame counters and 16-bit byte counter
    for (int n = 0; n < 300; n++) send(2, 1500, 1, 0, UC, 16'h0800, 16'h0);
    read(2, 2, "R13");
    read(2, 10, "R13");
    read(2, 11, "R13");
    read(2, 5, "R13");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
    end
    summary();
  end

endmodule